// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the small register window of a device through which several peers share one memory region. Software sees a 256-byte space on a simple 32-bit register bus. The space holds an interrupt enable (mask) bit, an interrupt status bit, a read-only identity register and a write-only doorbell. A doorbell write names a target peer and one of its interrupt vectors. The block forwards that request to the messaging fabric only when it is legal. It is legal when the device is set up for interrupts, the target is present in a locally held table of connected peers, and the vector lies below that peer's connected vector count. Any other doorbell is dropped without a trace.

Interrupts coming in from peers set the status bit. A status read returns the bit and clears it. When message-signalled delivery is switched off, the status bit gated by the mask drives a level-sensitive legacy interrupt line. A sideband port loads the connected-peer table one entry at a time. The number of table entries and the width of the per-peer vector count are parameters.

Top module: `shm_doorbell_regs`

## Requirements
- R1: After reset the mask and status bits are 0, `ring_valid` and `legacy_irq` are 0, and every peer-table entry is invalid, so no doorbell is accepted.
- R2: The register address is `reg_addr`. Word address `reg_addr[7:2]` 0 is the mask (bit 0 read/write), 1 is the status, 2 is the identity (read-only) and 3 is the doorbell (write-only). An access with `reg_addr[1:0]` non-zero is treated as reserved. All other locations, the unused bits of every register, and reads of the doorbell return 0. Writes to the identity register or to reserved locations change nothing.
- R3: Read data is registered. `reg_rdata` shows the value selected in the cycle in which `reg_rd` was sampled high, from the following cycle on, and holds it until the next read.
- R4: The identity register reads `{16'h0, cfg_own_id}` while `cfg_intr_en` is 1, and reads 0 while it is 0.
- R5: An accepted doorbell write produces `ring_valid` high for exactly one cycle, in the cycle after the write. It carries `ring_peer` = write data bits 31:16 and `ring_vector` = write data bits 15:0.
- R6: A doorbell write is dropped (`ring_valid` stays 0) when `cfg_intr_en` is 0 or `cfg_setup_done` is 0.
- R7: A doorbell write is dropped when no valid table entry holds the requested peer ID. Peer IDs span the full range 0 to 65535.
- R8: A doorbell write is dropped when the requested vector is greater than or equal to the vector count of the matching entry. When several valid entries hold the same peer ID, the entry with the lowest index decides.
- R9: A cycle with `tbl_load` high writes entry `tbl_index` with `tbl_valid`, `tbl_peer_id` and `tbl_nvec`. The new contents take effect from the next cycle. Loading `tbl_valid` = 0 removes the entry.
- R10: `peer_irq_in` high sets status bit 0 at the next edge. A status read clears it, but if `peer_irq_in` is high in the same cycle the bit stays 1. A status write loads bit 0 from write data bit 0, and an inbound interrupt takes priority over it.
- R11: `legacy_irq` is high exactly when status bit 0 and mask bit 0 are both 1 and `cfg_msi_en` is 0. It follows the registers with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_intr_en | input | 1 | Device configured for interrupts |
| cfg_setup_done | input | 1 | Interrupt setup complete |
| cfg_msi_en | input | 1 | Message-signalled interrupts enabled (disables the legacy line) |
| cfg_own_id | input | 16 | Device's own peer ID |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| tbl_load | input | 1 | Peer-table load strobe |
| tbl_index | input | IDX_W | Table entry to load |
| tbl_valid | input | 1 | Entry valid flag |
| tbl_peer_id | input | 16 | Entry peer ID |
| tbl_nvec | input | NVEC_W | Number of connected vectors of that peer |
| peer_irq_in | input | 1 | Inbound peer interrupt request |
| ring_valid | output | 1 | One-cycle pulse for an accepted doorbell |
| ring_peer | output | 16 | Target peer of the accepted doorbell |
| ring_vector | output | 16 | Vector of the accepted doorbell |
| legacy_irq | output | 1 | Level-sensitive legacy interrupt |

## Verification
The properties assume the configuration inputs and the peer table behave as quasi-static state. They may change between register operations, but their values in the cycle of a doorbell write are the ones that decide it. The stimulus drives every strobe and every configuration change half a cycle away from the sampling edge. It holds each strobe for exactly one cycle and leaves the table untouched while a doorbell is in flight. The properties also take `peer_irq_in` as a plain level sampled each cycle with no handshake. The bench pulses it for single cycles, alone and overlapping a status read or a status write.

// File: rtl/shm_db_pkg.sv
package shm_db_pkg;
  localparam int ID_W   = 16;
  localparam int VEC_W  = 16;
  localparam int DATA_W = 32;

  // word indices inside the 256-byte window
  localparam logic [5:0] W_MASK = 6'd0;
  localparam logic [5:0] W_STAT = 6'd1;
  localparam logic [5:0] W_POS  = 6'd2;
  localparam logic [5:0] W_BELL = 6'd3;

  function automatic logic [ID_W-1:0] bell_peer(input logic [DATA_W-1:0] w);
    return w[31:16];
  endfunction

  function automatic logic [VEC_W-1:0] bell_vec(input logic [DATA_W-1:0] w);
    return w[15:0];
  endfunction

  // vector is usable only below the connected count
  function automatic logic vec_in_range(input logic [15:0] vec, input logic [15:0] nvec);
    return vec < nvec;
  endfunction

  function automatic logic line_level(input logic stat, input logic mask, input logic msi);
    return stat & mask & ~msi;
  endfunction
endpackage

// File: rtl/shm_db_peer_table.sv
module shm_db_peer_table #(
  parameter int ENTRIES = 4,
  parameter int NVEC_W  = 5,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_valid,
  input  logic [15:0]       ld_peer,
  input  logic [NVEC_W-1:0] ld_nvec,
  input  logic [15:0]       lk_peer,
  output logic              lk_hit,
  output logic [NVEC_W-1:0] lk_nvec
);
  logic [ENTRIES-1:0] ent_match;
  logic [NVEC_W-1:0]  ent_nvec [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v_q;
    logic [15:0]       p_q;
    logic [NVEC_W-1:0] n_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
        n_q <= '0;
      end else if (ld_en && ld_idx == IDX_W'(g)) begin
        v_q <= ld_valid;
        p_q <= ld_peer;
        n_q <= ld_nvec;
      end
    end
    assign ent_match[g] = v_q && (p_q == lk_peer);
    assign ent_nvec[g]  = n_q;
  end

  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    lk_hit  = 1'b0;
    lk_nvec = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_match[i]) begin
        lk_hit  = 1'b1;
        lk_nvec = ent_nvec[i];
      end
    end
  end
endmodule

// File: rtl/shm_db_bell_filter.sv
module shm_db_bell_filter
  import shm_db_pkg::*;
#(
  parameter int NVEC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_bell,
  input  logic [DATA_W-1:0] wdata,
  input  logic              intr_en,
  input  logic              setup_done,
  input  logic              hit,
  input  logic [NVEC_W-1:0] nvec,
  output logic              accept,
  output logic              ring_valid,
  output logic [ID_W-1:0]   ring_peer,
  output logic [VEC_W-1:0]  ring_vector
);
  assign accept = wr_bell && intr_en && setup_done && hit &&
                  vec_in_range(bell_vec(wdata), 16'(nvec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_valid  <= 1'b0;
      ring_peer   <= '0;
      ring_vector <= '0;
    end else begin
      ring_valid <= accept;
      if (accept) begin
        ring_peer   <= bell_peer(wdata);
        ring_vector <= bell_vec(wdata);
      end
    end
  end
endmodule

// File: rtl/shm_db_status_line.sv
module shm_db_status_line
  import shm_db_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_mask,
  input  logic wr_stat,
  input  logic rd_stat,
  input  logic wbit,
  input  logic peer_irq,
  input  logic msi_en,
  output logic mask_q,
  output logic stat_q,
  output logic legacy_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wbit;
      if (peer_irq)     stat_q <= 1'b1;
      else if (wr_stat) stat_q <= wbit;
      else if (rd_stat) stat_q <= 1'b0;
    end
  end

  assign legacy_irq = line_level(stat_q, mask_q, msi_en);
endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import shm_db_pkg::*;
#(
  parameter int TBL_ENTRIES = 4,
  parameter int NVEC_W      = 5,
  localparam int IDX_W      = (TBL_ENTRIES > 1) ? $clog2(TBL_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_intr_en,
  input  logic              cfg_setup_done,
  input  logic              cfg_msi_en,
  input  logic [15:0]       cfg_own_id,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  input  logic              tbl_load,
  input  logic [IDX_W-1:0]  tbl_index,
  input  logic              tbl_valid,
  input  logic [15:0]       tbl_peer_id,
  input  logic [NVEC_W-1:0] tbl_nvec,
  input  logic              peer_irq_in,
  output logic              ring_valid,
  output logic [15:0]       ring_peer,
  output logic [15:0]       ring_vector,
  output logic              legacy_irq
);
  logic [5:0]        word;
  logic              aligned;
  logic              wr_mask, wr_stat, wr_bell, rd_stat;
  logic              lk_hit;
  logic [NVEC_W-1:0] lk_nvec;
  logic [15:0]       bell_nvec16;
  logic              bell_accept;
  logic              mask_q, stat_q;
  logic [31:0]       rd_value;

  assign word    = reg_addr[7:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign wr_mask = reg_wr && aligned && (word == W_MASK);
  assign wr_stat = reg_wr && aligned && (word == W_STAT);
  assign wr_bell = reg_wr && aligned && (word == W_BELL);
  assign rd_stat = reg_rd && aligned && (word == W_STAT);
  assign bell_nvec16 = 16'(lk_nvec);

  shm_db_peer_table #(.ENTRIES(TBL_ENTRIES), .NVEC_W(NVEC_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .ld_en(tbl_load), .ld_idx(tbl_index), .ld_valid(tbl_valid),
    .ld_peer(tbl_peer_id), .ld_nvec(tbl_nvec),
    .lk_peer(bell_peer(reg_wdata)), .lk_hit(lk_hit), .lk_nvec(lk_nvec)
  );

  shm_db_bell_filter #(.NVEC_W(NVEC_W)) filter_i (
    .clk(clk), .rst_n(rst_n),
    .wr_bell(wr_bell), .wdata(reg_wdata),
    .intr_en(cfg_intr_en), .setup_done(cfg_setup_done),
    .hit(lk_hit), .nvec(lk_nvec), .accept(bell_accept),
    .ring_valid(ring_valid), .ring_peer(ring_peer), .ring_vector(ring_vector)
  );

  shm_db_status_line status_i (
    .clk(clk), .rst_n(rst_n),
    .wr_mask(wr_mask), .wr_stat(wr_stat), .rd_stat(rd_stat),
    .wbit(reg_wdata[0]), .peer_irq(peer_irq_in), .msi_en(cfg_msi_en),
    .mask_q(mask_q), .stat_q(stat_q), .legacy_irq(legacy_irq)
  );

  always_comb begin
    rd_value = '0;
    if (aligned) begin
      case (word)
        W_MASK:  rd_value = {31'b0, mask_q};
        W_STAT:  rd_value = {31'b0, stat_q};
        W_POS:   rd_value = cfg_intr_en ? {16'b0, cfg_own_id} : 32'b0;
        default: rd_value = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_value;
  end
endmodule

// File: rtl/shm_doorbell_chk.sv
module shm_doorbell_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_intr_en,
  input logic        cfg_setup_done,
  input logic        cfg_msi_en,
  input logic [7:0]  reg_addr,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        peer_irq_in,
  input logic        ring_valid,
  input logic [15:0] ring_peer,
  input logic [15:0] ring_vector,
  input logic        legacy_irq,
  input logic        wr_bell,
  input logic        wr_stat,
  input logic        rd_stat,
  input logic        lk_hit,
  input logic [15:0] bell_nvec16,
  input logic        mask_q,
  input logic        stat_q
);
  assert_bell_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> $past(wr_bell && cfg_intr_en && cfg_setup_done));

  assert_bell_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> (ring_peer == $past(reg_wdata[31:16]) &&
                    ring_vector == $past(reg_wdata[15:0])));

  assert_bell_peer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> $past(lk_hit));

  assert_bell_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> (ring_vector < $past(bell_nvec16)));

  assert_stat_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    peer_irq_in |=> stat_q);

  assert_stat_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !peer_irq_in && !wr_stat) |=> !stat_q);

  assert_line_msi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_msi_en |-> !legacy_irq);

  assert_line_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q |-> !legacy_irq);

  assert_pos_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h08) |=> $stable(mask_q));
endmodule

bind shm_doorbell_regs shm_doorbell_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .cfg_intr_en(cfg_intr_en), .cfg_setup_done(cfg_setup_done), .cfg_msi_en(cfg_msi_en),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .peer_irq_in(peer_irq_in),
  .ring_valid(ring_valid), .ring_peer(ring_peer), .ring_vector(ring_vector),
  .legacy_irq(legacy_irq),
  .wr_bell(wr_bell), .wr_stat(wr_stat), .rd_stat(rd_stat),
  .lk_hit(lk_hit), .bell_nvec16(bell_nvec16),
  .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/shm_doorbell_regs_tb_top.sv
module shm_doorbell_regs_tb_top;
  localparam int N = 4;
  localparam int NV = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_intr_en = 0, cfg_setup_done = 0, cfg_msi_en = 0;
  logic [15:0] cfg_own_id = 16'hBEEF;
  logic [7:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic tbl_load = 0, tbl_valid = 0;
  logic [1:0] tbl_index = 0;
  logic [15:0] tbl_peer_id = 0;
  logic [NV-1:0] tbl_nvec = 0;
  logic peer_irq_in = 0;
  logic ring_valid, legacy_irq;
  logic [15:0] ring_peer, ring_vector;

  int checks = 0, failures = 0, cyc = 0;
  logic        m_valid [N];
  logic [15:0] m_peer  [N];
  int          m_nvec  [N];

  always #4 clk = ~clk;

  shm_doorbell_regs #(.TBL_ENTRIES(N), .NVEC_W(NV)) dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<60000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic load(input int idx, input logic v, input logic [15:0] p, input int nv);
    tbl_index = 2'(idx); tbl_valid = v; tbl_peer_id = p; tbl_nvec = NV'(nv); tbl_load = 1;
    @(negedge clk);
    tbl_load = 0;
    m_valid[idx] = v; m_peer[idx] = p; m_nvec[idx] = nv;
  endtask

  function automatic logic model_accept(input logic [15:0] p, input int v);
    if (!cfg_intr_en || !cfg_setup_done) return 1'b0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_peer[i] == p) return (v < m_nvec[i]);
    return 1'b0;
  endfunction

  // doorbell write and check of the resulting pulse
  task automatic bell(input string req, input logic [15:0] p, input logic [15:0] v);
    logic e;
    e = model_accept(p, int'(v));
    wr(8'h0C, {p, v});
    check(req, {31'b0, ring_valid}, {31'b0, e});
    if (e) begin
      check(req, {16'b0, ring_peer}, {16'b0, p});
      check(req, {16'b0, ring_vector}, {16'b0, v});
    end
    @(negedge clk);
    check(req, {31'b0, ring_valid}, 32'b0);
  endtask

  task automatic pulse_irq();
    peer_irq_in = 1;
    @(negedge clk);
    peer_irq_in = 0;
  endtask

  logic [31:0] d;
  logic [15:0] peers [6];

  initial begin
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_peer[i] = 0; m_nvec[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ring", {31'b0, ring_valid}, 0);
    check("R1 line", {31'b0, legacy_irq}, 0);
    rd(8'h00, d); check("R1 mask", d, 0);
    rd(8'h04, d); check("R1 stat", d, 0);
    cfg_intr_en = 1; cfg_setup_done = 1;
    bell("R1 empty table", 16'h0000, 16'h0000);

    // R9 load table
    load(0, 1, 16'h0003, 2);
    load(1, 1, 16'h1234, 5);
    load(2, 1, 16'hFFFF, 1);
    load(3, 1, 16'h0007, 0);

    // R7/R8 sweep peers x vectors
    peers[0] = 16'h0000; peers[1] = 16'h0003; peers[2] = 16'h0007;
    peers[3] = 16'h1234; peers[4] = 16'hFFFF; peers[5] = 16'h0005;
    for (int p = 0; p < 6; p++) begin
      for (int v = 0; v < 7; v++) bell("R7 R8 R5 sweep", peers[p], 16'(v));
      bell("R8 high vector", peers[p], 16'h8000);
    end

    // R6 configuration gating
    for (int c = 0; c < 4; c++) begin
      cfg_intr_en = c[0]; cfg_setup_done = c[1];
      @(negedge clk);
      bell("R6 gate", 16'h1234, 16'h0004);
    end
    cfg_intr_en = 1; cfg_setup_done = 1;

    // R8 duplicate peer: lowest index decides; R9 removal
    load(3, 1, 16'h0003, 9);
    bell("R8 lowest index", 16'h0003, 16'h0004);
    load(0, 0, 16'h0003, 2);
    bell("R9 invalidated", 16'h0003, 16'h0004);
    bell("R9 invalidated", 16'h0003, 16'h0009);

    // R2/R3/R4 address sweep
    wr(8'h00, 32'hFFFF_FFFF);
    for (int w = 0; w < 64; w++) begin
      rd(8'(w * 4), d);
      case (w)
        0: check("R2 R3 map mask", d, 32'h1);
        1: check("R2 R3 map stat", d, 32'h0);
        2: check("R4 pos", d, 32'h0000_BEEF);
        default: check("R2 reserved", d, 32'h0);
      endcase
    end
    rd(8'h01, d); check("R2 unaligned read", d, 0);
    reg_addr = 8'h00; @(negedge clk);
    check("R3 hold", reg_rdata, 0);
    cfg_intr_en = 0;
    rd(8'h08, d); check("R4 pos off", d, 0);
    cfg_intr_en = 1;
    wr(8'h00, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 ro write mask", d, 0);
    rd(8'h04, d); check("R2 ro write stat", d, 0);
    wr(8'h0D, {16'h1234, 16'h0000});
    check("R2 unaligned bell", {31'b0, ring_valid}, 0);
    rd(8'h0C, d); check("R2 bell reads zero", d, 0);

    // R10 status behaviour
    pulse_irq();
    rd(8'h04, d); check("R10 set", d, 1);
    rd(8'h04, d); check("R10 clear", d, 0);
    peer_irq_in = 1;
    rd(8'h04, d); check("R10 collide read", d, 0);
    peer_irq_in = 0;
    rd(8'h04, d); check("R10 collide kept", d, 1);
    rd(8'h04, d); check("R10 cleared", d, 0);
    wr(8'h04, 32'h1);
    rd(8'h04, d); check("R10 write one", d, 1);
    wr(8'h04, 32'h1); wr(8'h04, 32'h0);
    rd(8'h04, d); check("R10 write zero", d, 0);
    peer_irq_in = 1; wr(8'h04, 32'h0); peer_irq_in = 0;
    rd(8'h04, d); check("R10 irq over write", d, 1);

    // R11 legacy line sweep
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, {31'b0, c[0]});
      cfg_msi_en = c[1];
      pulse_irq();
      check("R11 line", {31'b0, legacy_irq}, {31'b0, c[0] & ~c[1]});
      rd(8'h04, d);
      check("R11 line idle", {31'b0, legacy_irq}, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule